// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block is a bus-mapped peripheral with two independent 8-bit parallel sides, A and B. Each side has an output data register, a direction register that decides pin by pin whether the block drives the pin or samples it, a control register, and two control lines (C1, C2). C1 and C2 are used as edge-sensitive inputs that raise interrupt flags. Software reaches the block through a simple synchronous read and write strobe. Only the low two address bits select a register.

Each side's data address is shared between its data register and its direction register. A bit in that side's control register chooses which of the two a read or write reaches. A read of the data register has a side effect: it acknowledges that side's interrupts.

Each side drives its own active-high interrupt output. The output combines the two flags with their enable bits.

Top module: `pia_dual`

## Requirements
- R1: After reset, every register reads 0, all pin output enables are 0 and both interrupt outputs are 0.
- R2: Only bus_addr[1:0] select the register, and higher address bits are ignored. Index 0 is the A data/direction register, 1 is A control, 2 is the B data/direction register, 3 is B control.
- R3: Control bit 2 steers the side's data address for both reads and writes. When it is 1, the access reaches the data register. When it is 0, it reaches the direction register.
- R4: A control write stores bits 5..0 only. A control read returns the C1 flag in bit 7, the C2 flag in bit 6 and the stored bits in 5..0.
- R5: The pin enable equals the direction register, and the pin output equals data AND direction. The enables change only in the cycle after a bus write.
- R6: A data register read returns the register bit for pins whose direction is 1, and the live pin input for pins whose direction is 0.
- R7: The C1 flag is set on a C1 edge. Control bit 1 picks the active edge: 1 means rising, 0 means falling. The other edge has no effect.
- R8: The C2 flag is set on a C2 edge. Control bit 4 picks the active edge: 1 means rising, 0 means falling. No edge sets it while control bit 5 is 1.
- R9: A data register read clears both flags of that side at the end of the read cycle. A direction register read leaves them unchanged.
- R10: Each side's interrupt output is (C1 flag AND control bit 0) OR (C2 flag AND control bit 3).
- R11: When an active edge and a clearing read fall in the same cycle, the flag ends up set.
- R12: The two sides are independent. Activity on one side leaves the other side's registers, flags and interrupt output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register address; only bits 1..0 are decoded |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects happen at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pa_in | input | 8 | Side A pin levels |
| pa_out | output | 8 | Side A pin drive values |
| pa_oe | output | 8 | Side A pin drive enables |
| ca1 | input | 1 | Side A control line 1 |
| ca2 | input | 1 | Side A control line 2 |
| irq_a | output | 1 | Side A interrupt, active high |
| pb_in | input | 8 | Side B pin levels |
| pb_out | output | 8 | Side B pin drive values |
| pb_oe | output | 8 | Side B pin drive enables |
| cb1 | input | 1 | Side B control line 1 |
| cb2 | input | 1 | Side B control line 2 |
| irq_b | output | 1 | Side B interrupt, active high |

## Verification
A corrupted direction or data register appears at once on the pin enables and drive values. A wrong selection bit shows up on the very next access to the shared data address, which returns the wrong register. A flag that is set or cleared wrongly appears on the interrupt output in the cycle after the edge or the read, if its enable is on. Otherwise it appears in bits 7..6 of the next control read. Edge-polarity and simultaneous set/clear faults therefore show up within two cycles of the stimulus.

// File: rtl/pia_dual.sv
module pia_dual #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    pa_in,
  output logic [7:0]    pa_out,
  output logic [7:0]    pa_oe,
  input  logic          ca1,
  input  logic          ca2,
  output logic          irq_a,
  input  logic [7:0]    pb_in,
  output logic [7:0]    pb_out,
  output logic [7:0]    pb_oe,
  input  logic          cb1,
  input  logic          cb2,
  output logic          irq_b
);
  localparam int SIDES = 2;

  logic [1:0] idx;
  logic       unused_hi;
  logic [7:0] rd_side  [SIDES];
  logic [7:0] pin_drv  [SIDES];
  logic [7:0] pin_en   [SIDES];
  logic       irq_side [SIDES];

  assign idx       = bus_addr[1:0];
  assign unused_hi = ^bus_addr;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam logic ME = 1'(s);

    logic [7:0] data_q, dir_q, pins, view;
    logic [5:0] cr_q;
    logic       f1_q, f2_q, l1_q, l2_q;
    logic       l1, l2, hit, at_data, at_ctrl, e1, e2, ack;

    assign pins = ME ? pb_in : pa_in;
    assign l1   = ME ? cb1 : ca1;
    assign l2   = ME ? cb2 : ca2;

    assign hit     = (idx[1] == ME);
    assign at_data = hit & ~idx[0];
    assign at_ctrl = hit &  idx[0];

    assign e1  = cr_q[1] ? (l1 & ~l1_q) : (~l1 & l1_q);
    assign e2  = ~cr_q[5] & (cr_q[4] ? (l2 & ~l2_q) : (~l2 & l2_q));
    assign ack = bus_rd & at_data & cr_q[2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q <= '0;
        dir_q  <= '0;
        cr_q   <= '0;
        f1_q   <= 1'b0;
        f2_q   <= 1'b0;
        l1_q   <= 1'b0;
        l2_q   <= 1'b0;
      end else begin
        l1_q <= l1;
        l2_q <= l2;
        if (bus_wr && at_ctrl) cr_q <= bus_wdata[5:0];
        if (bus_wr && at_data) begin
          if (cr_q[2]) data_q <= bus_wdata;
          else         dir_q  <= bus_wdata;
        end
        if (e1)       f1_q <= 1'b1;
        else if (ack) f1_q <= 1'b0;
        if (e2)       f2_q <= 1'b1;
        else if (ack) f2_q <= 1'b0;
      end
    end

    assign view        = (dir_q & data_q) | (~dir_q & pins);
    assign rd_side[s]  = idx[0] ? {f1_q, f2_q, cr_q} : (cr_q[2] ? view : dir_q);
    assign pin_drv[s]  = data_q & dir_q;
    assign pin_en[s]   = dir_q;
    assign irq_side[s] = (f1_q & cr_q[0]) | (f2_q & cr_q[3]);
  end

  assign bus_rdata = idx[1] ? rd_side[1] : rd_side[0];
  assign pa_out    = pin_drv[0];
  assign pa_oe     = pin_en[0];
  assign pb_out    = pin_drv[1];
  assign pb_oe     = pin_en[1];
  assign irq_a     = irq_side[0];
  assign irq_b     = irq_side[1];
endmodule

// File: rtl/pia_dual_chk.sv
module pia_dual_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    pa_oe,
  input logic [7:0]    pb_oe,
  input logic          irq_a,
  input logic          irq_b
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_a == 1'b0 && irq_b == 1'b0 && pa_oe == 8'h00 && pb_oe == 8'h00));

  a_r5_oe_a_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pa_oe) |-> $past(bus_wr) && $past(bus_addr[1:0]) == 2'd0);

  a_r5_oe_b_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pb_oe) |-> $past(bus_wr) && $past(bus_addr[1:0]) == 2'd2);

  a_r9_irq_a_drop_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_a) |-> $past(bus_rd || bus_wr) && $past(bus_addr[1]) == 1'b0);

  a_r9_irq_b_drop_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_b) |-> $past(bus_rd || bus_wr) && $past(bus_addr[1]) == 1'b1);
endmodule

bind pia_dual pia_dual_chk #(.AW(AW)) chk_i (.*);

// File: tb/pia_dual_tb_top.sv
module pia_dual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe;
  logic [7:0] pb_in = '0, pb_out, pb_oe;
  logic       ca1 = 1'b0, ca2 = 1'b0, cb1 = 1'b0, cb2 = 1'b0;
  logic       irq_a, irq_b;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  pia_dual #(.AW(4)) dut_i (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 irq_a", {7'b0, irq_a}, 8'h00);
    chk("R1 irq_b", {7'b0, irq_b}, 8'h00);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    rd(4'd0, 8'h00, "R1 reg0");
    rd(4'd1, 8'h00, "R1 reg1");
    rd(4'd2, 8'h00, "R1 reg2");
    rd(4'd3, 8'h00, "R1 reg3");

    wr(4'd0, 8'h0F);
    rd(4'd0, 8'h0F, "R3 dir read");
    chk("R5 pa_oe", pa_oe, 8'h0F);
    chk("R5 pa_out before data", pa_out, 8'h00);
    wr(4'd5, 8'hC4);
    rd(4'd1, 8'h04, "R4 ctrl via alias, top bits dropped (R2)");
    wr(4'd0, 8'hA5);
    pa_in = 8'h30;
    chk("R5 pa_out", pa_out, 8'h05);
    chk("R3 dir kept", pa_oe, 8'h0F);
    rd(4'd0, 8'h35, "R6 mixed read");
    rd(4'd8, 8'h35, "R2 high bits ignored");

    ca1 = 1'b1; idle(2);
    rd(4'd1, 8'h04, "R7 inactive rising edge");
    ca1 = 1'b0; idle(2);
    rd(4'd1, 8'h84, "R7 falling edge sets");
    chk("R10 disabled", {7'b0, irq_a}, 8'h00);
    wr(4'd1, 8'h05);
    chk("R10 enable1", {7'b0, irq_a}, 8'h01);
    rd(4'd0, 8'h35, "R9 data read");
    rd(4'd1, 8'h05, "R9 flags cleared");
    chk("R9 irq_a low", {7'b0, irq_a}, 8'h00);

    wr(4'd1, 8'h03);
    ca1 = 1'b1; idle(2);
    rd(4'd1, 8'h83, "R7 rising edge sets");
    rd(4'd0, 8'h0F, "R9 dir read");
    rd(4'd1, 8'h83, "R9 dir read keeps flag");
    chk("R10 irq on", {7'b0, irq_a}, 8'h01);

    wr(4'd1, 8'h1C);
    rd(4'd0, 8'h35, "R9 clear again");
    rd(4'd1, 8'h1C, "R9 flag1 gone");
    ca2 = 1'b1; idle(2);
    rd(4'd1, 8'h5C, "R8 rising C2");
    chk("R10 enable2", {7'b0, irq_a}, 8'h01);
    rd(4'd0, 8'h35, "R9 clear C2");
    ca2 = 1'b0; idle(2);
    rd(4'd1, 8'h1C, "R8 inactive falling C2");
    wr(4'd1, 8'h3C);
    ca2 = 1'b1; idle(2);
    rd(4'd1, 8'h3C, "R8 bit5 blocks C2");
    chk("R8 irq stays low", {7'b0, irq_a}, 8'h00);

    wr(4'd1, 8'h1C);
    ca2 = 1'b0; idle(2);
    ca2 = 1'b1;
    rd(4'd0, 8'h35, "R11 read with edge");
    rd(4'd1, 8'h5C, "R11 set wins");

    wr(4'd2, 8'hFF);
    wr(4'd3, 8'h05);
    wr(4'd2, 8'h3C);
    pb_in = 8'hC3;
    chk("R12 pb_oe", pb_oe, 8'hFF);
    chk("R12 pb_out", pb_out, 8'h3C);
    rd(4'd2, 8'h3C, "R12 B data");
    cb1 = 1'b1; idle(1);
    cb1 = 1'b0; idle(2);
    rd(4'd3, 8'h85, "R12 B C1 flag");
    chk("R12 irq_b", {7'b0, irq_b}, 8'h01);
    rd(4'd1, 8'h5C, "R12 A untouched");
    chk("R12 irq_a untouched", {7'b0, irq_a}, 8'h01);
    rd(4'd2, 8'h3C, "R12 B clear");
    chk("R12 irq_b cleared", {7'b0, irq_b}, 8'h00);
    chk("R12 pa_oe untouched", pa_oe, 8'h0F);

    idle(2);
    if (exp_q.size() != 0) chk("scoreboard-leftover", 8'h01, 8'h00);
    finish_run();
  end

  initial begin
    #(20 * 20000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end
endmodule